// File: doc/BRIEF.md
# 1-Wire Search Triplet Engine

This block carries out a single branch step of a 1-Wire ROM search. The caller gives it a preferred branch and a start pulse. The engine then runs three bus slots in a fixed order. First it reads the true bit of the current ROM position from every device on the bus. Next it reads the inverted copy of that bit. Finally it writes back the branch it has chosen, so that devices which do not match drop out of the search. The bus itself sits behind a single-bit transfer layer. That layer offers a bit-read request and a bit-write request, and it answers each with a done strobe. The read strobe also carries the sampled bit.

The two sampled bits and the chosen branch are packed into one 3-bit code. If no device answers, the write slot is skipped. Each slot has a watchdog measured in clock cycles. If a slot's handshake never arrives, the step is aborted and an error is flagged. The search controller above this block walks the 64 ROM positions. It does so by calling this engine once per position.

Top module: `owt_triplet`

## Requirements
- R1: A step issues its bus requests in a strict order: read of the true bit, then read of the inverted bit, then (when required) the write. The read request and the write request are never active together.
- R2: The result is packed as bit 0 = true bit sampled, bit 1 = inverted bit sampled, bit 2 = branch taken.
- R3: When both sampled bits are 1, no device is present. The result is 3'b011 and no write slot is issued.
- R4: When both sampled bits are 0, the branch equals the preferred direction latched at start. That branch is written to the bus, and the result is 3'b100 (preferred 1) or 3'b000 (preferred 0).
- R5: When exactly one sampled bit is 1, the branch equals the true bit. That branch is written to the bus, and the result is 3'b101 (true bit 1) or 3'b010 (true bit 0).
- R6: A slot whose done strobe has not arrived after TIMEOUT_CYC clock edges in that slot aborts the step. `done_o` then rises on that edge, with `err_o` = 1 and the result = 3'b011. Any slot still to come is skipped.
- R7: A start pulse seen while idle latches `pref_dir_i` and begins a step. A start pulse during a step is ignored: it neither alters the preferred direction nor queues another step.
- R8: `done_o` is high for exactly one cycle per step. `result_o` and `err_o` stay constant between completions, and a clean completion clears `err_o`.
- R9: After synchronous reset, both requests, `done_o`, `err_o` and `busy_o` are low, and `result_o` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one search step (accepted only while idle) |
| pref_dir_i | input | 1 | Branch to take when devices disagree |
| rd_req_o | output | 1 | Bit-read slot request, held until `rd_done_i` |
| rd_done_i | input | 1 | Bit-read completion strobe |
| rd_bit_i | input | 1 | Sampled bus bit, valid with `rd_done_i` |
| wr_req_o | output | 1 | Bit-write slot request, held until `wr_done_i` |
| wr_done_i | input | 1 | Bit-write completion strobe |
| wr_bit_o | output | 1 | Branch bit to write, valid with `wr_req_o` |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last step aborted on a slot timeout |
| result_o | output | 3 | Encoded outcome of the last step |

## Verification
The bench drives every combination of sampled bits, including the disagreement case under both preferred directions. A design with a wrong branch rule would write the wrong bit or return a code whose top bit is flipped. In the no-device case it counts rising edges of the write request. A design that forgets to skip the write slot would show one write where none belongs. Each of the three slots is starved in turn, and the abort cycle is checked to the exact edge. An off-by-one timer would finish a cycle early or late, and a missing abort path would hang until the watchdog fires. Start pulses are injected mid-step with the opposite preference. A design that re-latches or queues them would report 3'b000 instead of 3'b100, or would launch a second read afterwards.

// File: rtl/owt_pkg.sv
package owt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_TRU = 2'd1,
    ST_RD_INV = 2'd2,
    ST_WR_DIR = 2'd3
  } owt_state_e;

  // code returned when nobody answers or a slot times out
  localparam logic [2:0] CODE_ABSENT = 3'b011;

endpackage

// File: rtl/owt_branch_pick.sv
module owt_branch_pick (
  input  logic tru_i,
  input  logic inv_i,
  input  logic pref_i,
  output logic dir_o,
  output logic absent_o
);

  always_comb begin
    absent_o = tru_i & inv_i;
    // a single set bit forces the branch; two clear bits mean a conflict
    dir_o    = (tru_i ^ inv_i) ? tru_i : pref_i;
  end

endmodule

// File: rtl/owt_slot_timer.sv
module owt_slot_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);

  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == LIMIT);

endmodule

// File: rtl/owt_triplet.sv
module owt_triplet #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       pref_dir_i,
  output logic       rd_req_o,
  input  logic       rd_done_i,
  input  logic       rd_bit_i,
  output logic       wr_req_o,
  input  logic       wr_done_i,
  output logic       wr_bit_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [2:0] result_o
);

  import owt_pkg::*;

  owt_state_e state_q;
  logic       pref_q;
  logic       tru_q;
  logic       inv_q;
  logic       dir_q;
  logic       done_q;
  logic       err_q;
  logic [2:0] res_q;

  logic slot_ack;
  logic slot_exp;
  logic pick_dir;
  logic pick_absent;

  assign rd_req_o = (state_q == ST_RD_TRU) || (state_q == ST_RD_INV);
  assign wr_req_o = (state_q == ST_WR_DIR);
  assign slot_ack = (rd_req_o && rd_done_i) || (wr_req_o && wr_done_i);

  owt_slot_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (state_q != ST_IDLE),
    .restart_i (slot_ack),
    .expired_o (slot_exp)
  );

  // the inverted bit is consumed straight off the bus strobe
  owt_branch_pick u_pick (
    .tru_i    (tru_q),
    .inv_i    (rd_bit_i),
    .pref_i   (pref_q),
    .dir_o    (pick_dir),
    .absent_o (pick_absent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pref_q  <= 1'b0;
      tru_q   <= 1'b0;
      inv_q   <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= 3'b000;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            pref_q  <= pref_dir_i;
            state_q <= ST_RD_TRU;
          end
        end
        ST_RD_TRU: begin
          if (rd_done_i) begin
            tru_q   <= rd_bit_i;
            state_q <= ST_RD_INV;
          end else if (slot_exp) begin
            res_q   <= CODE_ABSENT;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RD_INV: begin
          if (rd_done_i) begin
            inv_q <= rd_bit_i;
            dir_q <= pick_dir;
            if (pick_absent) begin
              res_q   <= CODE_ABSENT;
              err_q   <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WR_DIR;
            end
          end else if (slot_exp) begin
            res_q   <= CODE_ABSENT;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WR_DIR: begin
          if (wr_done_i) begin
            res_q   <= {dir_q, inv_q, tru_q};
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (slot_exp) begin
            res_q   <= CODE_ABSENT;
            err_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_bit_o = dir_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;

endmodule

// File: rtl/owt_triplet_chk.sv
module owt_triplet_chk #(
  parameter int TIMEOUT_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_req_o,
  input logic       rd_done_i,
  input logic       wr_req_o,
  input logic       wr_done_i,
  input logic       done_o,
  input logic       err_o,
  input logic [2:0] result_o
);

  localparam int WW = $clog2(TIMEOUT_CYC + 2) + 1;

  logic [WW-1:0] wait_cnt;

  // consecutive edges spent in a slot without its strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
    end else if ((rd_req_o && !rd_done_i) || (wr_req_o && !wr_done_i)) begin
      wait_cnt <= wait_cnt + 1'b1;
    end else begin
      wait_cnt <= '0;
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_o && wr_req_o)); // R1

  AST_ABSENT_NO_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (done_o && result_o[1:0] == 2'b11) |-> !result_o[2]); // R3

  AST_SINGLE_FORCES_DIR: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o && (result_o[0] ^ result_o[1])) |-> (result_o[2] == result_o[0])); // R5

  AST_SLOT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= WW'(TIMEOUT_CYC)); // R6

  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (result_o == 3'b011)); // R6

  AST_ERR_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(err_o))); // R8

endmodule

bind owt_triplet owt_triplet_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req_o  (rd_req_o),
  .rd_done_i (rd_done_i),
  .wr_req_o  (wr_req_o),
  .wr_done_i (wr_done_i),
  .done_o    (done_o),
  .err_o     (err_o),
  .result_o  (result_o)
);

// File: tb/owt_triplet_bench.sv
module owt_triplet_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TO = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       pref_dir_i = 1'b0;
  logic       rd_done_i = 1'b0;
  logic       rd_bit_i = 1'b0;
  logic       wr_done_i = 1'b0;
  logic       rd_req_o, wr_req_o, wr_bit_o, busy_o, done_o, err_o;
  logic [2:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  int wr_rises = 0;
  logic wr_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owt_triplet #(.TIMEOUT_CYC(TO)) u_owt_triplet (
    .clk(clk), .rst(rst), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .rd_req_o(rd_req_o), .rd_done_i(rd_done_i), .rd_bit_i(rd_bit_i),
    .wr_req_o(wr_req_o), .wr_done_i(wr_done_i), .wr_bit_o(wr_bit_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .result_o(result_o)
  );

  always @(posedge clk) begin
    if (wr_req_o && !wr_prev) wr_rises = wr_rises + 1;
    wr_prev = wr_req_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic pref);
    @(negedge clk);
    start_i = 1'b1; pref_dir_i = pref;
    @(negedge clk);
    start_i = 1'b0; pref_dir_i = ~pref;
  endtask

  task automatic serve_read(input logic b, input int dly);
    int g = 0;
    while (!rd_req_o && g < 50) begin @(negedge clk); g++; end
    repeat (dly) @(negedge clk);
    rd_bit_i = b; rd_done_i = 1'b1;
    @(negedge clk);
    rd_done_i = 1'b0; rd_bit_i = 1'b0;
  endtask

  task automatic serve_write(input logic exp_dir, input int dly, input string req);
    int g = 0;
    while (!wr_req_o && g < 50) begin @(negedge clk); g++; end
    chk(wr_req_o && !rd_req_o, "R1 write slot after reads", int'(wr_req_o), 1);
    chk(wr_bit_o == exp_dir, req, int'(wr_bit_o), int'(exp_dir));
    repeat (dly) @(negedge clk);
    wr_done_i = 1'b1;
    @(negedge clk);
    wr_done_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_step(input logic pref, input logic tb, input logic ib, input string req);
    logic absent, dir;
    logic [2:0] code;
    int r0, cyc;
    logic [2:0] held;
    absent = tb & ib;
    dir = (tb ^ ib) ? tb : pref;
    code = absent ? 3'b011 : {dir, ib, tb};
    r0 = wr_rises;
    pulse_start(pref);
    serve_read(tb, 1);
    serve_read(ib, 2);
    if (!absent) serve_write(dir, 1, {req, " written branch"});
    wait_done(cyc);
    chk(done_o == 1'b1, {req, " done seen"}, int'(done_o), 1);
    chk(result_o == code, {req, " R2 result code"}, int'(result_o), int'(code));
    chk(err_o == 1'b0, {req, " err clear"}, int'(err_o), 0);
    chk((wr_rises - r0) == (absent ? 0 : 1), {req, " write slots"}, wr_rises - r0, absent ? 0 : 1);
    held = result_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done single cycle", int'(done_o), 0);
    repeat (2) @(negedge clk);
    chk(result_o == held, "R8 result held", int'(result_o), int'(held));
  endtask

  task automatic t_timeout(input int slot);
    int r0, cyc;
    r0 = wr_rises;
    pulse_start(1'b0);
    if (slot >= 1) serve_read(1'b0, 1);
    if (slot >= 2) serve_read(1'b1, 1);
    wait_done(cyc);
    chk(cyc == TO, $sformatf("R6 abort edge slot %0d", slot), cyc, TO);
    chk(err_o == 1'b1, "R6 err with done", int'(err_o), 1);
    chk(result_o == 3'b011, "R6 abort code", int'(result_o), 3);
    chk((wr_rises - r0) == (slot == 2 ? 1 : 0), "R6 later slots skipped", wr_rises - r0, slot == 2 ? 1 : 0);
    @(negedge clk);
    chk(!rd_req_o && !wr_req_o && !busy_o, "R6 idle after abort", int'(busy_o), 0);
  endtask

  task automatic t_busy_start;
    int cyc, r0;
    pulse_start(1'b1);
    @(negedge clk); start_i = 1'b1; pref_dir_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    serve_read(1'b0, 1);
    start_i = 1'b1; pref_dir_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    serve_read(1'b0, 1);
    serve_write(1'b1, 1, "R7 preference kept during step");
    wait_done(cyc);
    chk(result_o == 3'b100, "R7 ignored start result", int'(result_o), 4);
    r0 = 0;
    repeat (6) begin
      @(negedge clk);
      if (rd_req_o || busy_o) r0++;
    end
    chk(r0 == 0, "R7 no queued step", r0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req_o && !wr_req_o && !done_o && !err_o && !busy_o, "R9 reset outputs", 0, 0);
    chk(result_o == 3'b000, "R9 reset result", int'(result_o), 0);

    t_step(1'b0, 1'b0, 1'b0, "R4 conflict pref0");
    t_step(1'b1, 1'b0, 1'b0, "R4 conflict pref1");
    t_step(1'b0, 1'b1, 1'b0, "R5 true bit one");
    t_step(1'b1, 1'b0, 1'b1, "R5 true bit zero");
    t_step(1'b0, 1'b1, 1'b1, "R3 absent");
    t_timeout(0);
    t_step(1'b1, 1'b1, 1'b0, "R8 clean after abort");
    t_timeout(1);
    t_timeout(2);
    t_busy_start();
    t_step(1'b1, 1'b1, 1'b1, "R3 absent pref1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule